// File: doc/BRIEF.md
# Floating-Point Store Format Converter

This block sits in the store path of a load-store unit. It receives the 64-bit contents of a floating-point register, a tag saying whether that register currently holds a single-precision or a double-precision operand, and an operation code. It produces the image that goes to memory. A store-single produces a 32-bit word. A store-double produces a 64-bit doubleword. A store-as-integer-word produces a 32-bit word taken straight from the register. Addresses, base-register update, the memory port and exception signalling belong to other blocks.

A register tagged single keeps its IEEE single image in bits 31:0. A register tagged double holds an IEEE double image. The block first sorts the operand into one of six classes: zero, denormal, normal, infinity, quiet NaN or signaling NaN. Then it picks the conversion that the class and the tag call for. Doubles too small for the single format are shifted into a single denormal or flushed to zero, with no rounding. Single denormals are renormalised when they are widened. Signaling NaNs are never quieted.

By default the result is registered, so it appears one clock after the request. Setting the parameter `OUT_REG` to 0 selects a purely combinational variant.

Top module: `fsc_store_convert`

## Requirements
- R1: Operation codes on `op_sel` are 00 store-single, 01 store-double, 10 store-as-integer-word and 11 reserved. `tag_single`=1 marks a single operand held in bits 31:0. For a store-single of a single-tagged operand, `store_data` is {32 zeros, bits 31:0 unchanged} for every class, and `store_wide`=0.
- R2: For a store-single of a double-tagged normal operand with biased exponent E > 896, the output word is {sign, low 8 bits of (E-896), fraction bits 51:29}, truncated.
- R3: For a store-single of a double-tagged normal operand with 1 <= E <= 896, the output has exponent field 0. Its fraction is the 24-bit value {1, fraction bits 51:29} shifted right by 897-E and truncated to 23 bits, which is zero when the shift is 24 or more.
- R4: For a store-single of a double-tagged zero or double-tagged denormal, the output is a zero that keeps the operand's sign.
- R5: For a store-single of a double-tagged infinity, the output is a single infinity of the same sign. For a double-tagged quiet NaN (fraction bit 51 = 1), the output is {sign, 8'hFF, fraction bits 51:29}.
- R6: A signaling NaN is never quieted. On store-single of a double-tagged signaling NaN, the output fraction is bits 51:29 with bit 22 left at 0. If those bits are all zero, bit 0 is set so the result stays a NaN. On store-double of a single-tagged signaling NaN, output bit 51 stays 0.
- R7: For a store-double of a double-tagged operand, `store_data` equals `fpr_value` and `store_wide`=1.
- R8: For a store-double of a single-tagged normal, zero, infinity or NaN, the output is the exact double image of that value. The exponent is rebiased by +896 (or forced to all ones for infinity and NaN), the fraction is the single fraction followed by 29 zeros, and `store_wide`=1.
- R9: For a store-double of a single-tagged denormal with L leading zeros in its 23-bit fraction, the output is normalised. Its exponent is 896-L and its fraction is the single fraction shifted left by L+1, so the value is exact.
- R10: For a store-as-integer-word, `store_data` is {32 zeros, `fpr_value` bits 31:0}, whatever the tag and class, and `store_wide`=0.
- R11: For the reserved code 11, `store_data` is all zeros and `store_wide`=0.
- R12: With `OUT_REG`=1, `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `store_data` and `store_wide` in that cycle belong to that request.
- R13: While `rst_n` is low, `out_valid`, `store_data` and `store_wide` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A store conversion is requested this cycle |
| fpr_value | input | 64 | Register contents |
| tag_single | input | 1 | 1: single operand in bits 31:0; 0: double image |
| op_sel | input | 2 | 00 single, 01 double, 10 integer word, 11 reserved |
| out_valid | output | 1 | Result valid |
| store_data | output | 64 | Memory image, right-aligned when 32 bits |
| store_wide | output | 1 | 1 when the image is 64 bits |

## Verification
In the default registered variant, every result (data, width flag and valid) is due exactly one clock after the cycle in which the request is presented. The valid flag drops again one clock after the request is withdrawn. The bench drives each request on a falling edge and holds it across one rising edge. It then samples all three outputs on the next falling edge, which is the first instant the registered result can be seen and is well away from the edge that loads it. Requests are spaced so that each sample belongs to exactly one request. The bench also samples out_valid one falling edge later to confirm that it has dropped.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
   localparam int D_EXP    = 11;
   localparam int D_FRAC   = 52;
   localparam int S_EXP    = 8;
   localparam int S_FRAC   = 23;
   localparam int D_W      = 1 + D_EXP + D_FRAC;
   localparam int S_W      = 1 + S_EXP + S_FRAC;
   localparam int D_BIAS   = (1 << (D_EXP - 1)) - 1;
   localparam int S_BIAS   = (1 << (S_EXP - 1)) - 1;
   localparam int BIAS_GAP = D_BIAS - S_BIAS;
   localparam int DROP_W   = D_FRAC - S_FRAC;

   typedef enum logic [2:0] {
      CLS_ZERO, CLS_DENORM, CLS_NORM, CLS_INF, CLS_QNAN, CLS_SNAN
   } fp_class_e;

   typedef enum logic [1:0] {
      OP_ST_SGL = 2'b00,
      OP_ST_DBL = 2'b01,
      OP_ST_IWD = 2'b10,
      OP_ST_RSV = 2'b11
   } st_op_e;
endpackage

// File: rtl/fsc_classify.sv
module fsc_classify #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W-1:0] mag_bits,
   output fsc_pkg::fp_class_e      cls
);
   import fsc_pkg::*;

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_fmt
      $error("fsc_classify: format too narrow");
   end

   logic [EXP_W-1:0]  ex;
   logic [FRAC_W-1:0] fr;

   assign ex = mag_bits[EXP_W+FRAC_W-1 -: EXP_W];
   assign fr = mag_bits[FRAC_W-1:0];

   always_comb begin
      if (ex == '0)
         cls = (fr == '0) ? CLS_ZERO : CLS_DENORM;
      else if (&ex)
         cls = (fr == '0) ? CLS_INF : (fr[FRAC_W-1] ? CLS_QNAN : CLS_SNAN);
      else
         cls = CLS_NORM;
   end
endmodule

// File: rtl/fsc_narrow.sv
module fsc_narrow (
   input  logic [fsc_pkg::D_W-1:0] dval,
   input  fsc_pkg::fp_class_e      cls,
   output logic [fsc_pkg::S_W-1:0] sval
);
   import fsc_pkg::*;

   localparam logic [D_EXP-1:0] GAP   = D_EXP'(BIAS_GAP);
   localparam logic [D_EXP-1:0] GAP_1 = D_EXP'(BIAS_GAP + 1);

   logic              sgn;
   logic [D_EXP-1:0]  ex;
   logic [S_FRAC-1:0] hi;
   logic              lo_nz;
   logic [S_FRAC:0]   mant;
   logic [D_EXP-1:0]  shamt;
   logic [S_FRAC-1:0] den;
   logic [S_EXP-1:0]  reb;

   assign sgn   = dval[D_W-1];
   assign ex    = dval[D_W-2 -: D_EXP];
   assign hi    = dval[D_FRAC-1 -: S_FRAC];
   assign lo_nz = |dval[DROP_W-1:0];
   assign mant  = {1'b1, hi};
   assign shamt = GAP_1 - ex;
   assign den   = S_FRAC'(mant >> shamt[4:0]);
   assign reb   = S_EXP'(ex - GAP);

   always_comb begin
      unique case (cls)
         CLS_ZERO, CLS_DENORM: sval = {sgn, {(S_W-1){1'b0}}};
         CLS_INF:              sval = {sgn, {S_EXP{1'b1}}, {S_FRAC{1'b0}}};
         CLS_QNAN, CLS_SNAN:   sval = {sgn, {S_EXP{1'b1}},
                                       hi | {{(S_FRAC-1){1'b0}}, (~|hi) & lo_nz}};
         default: begin
            if (ex > GAP)
               sval = {sgn, reb, hi};
            else if (shamt >= D_EXP'(S_FRAC + 1))
               sval = {sgn, {(S_W-1){1'b0}}};
            else
               sval = {sgn, {S_EXP{1'b0}}, den};
         end
      endcase
   end
endmodule

// File: rtl/fsc_widen.sv
module fsc_widen (
   input  logic [fsc_pkg::S_W-1:0] sval,
   input  fsc_pkg::fp_class_e      cls,
   output logic [fsc_pkg::D_W-1:0] dval
);
   import fsc_pkg::*;

   localparam int LZ_W = $clog2(S_FRAC + 1);

   logic              sgn;
   logic [S_EXP-1:0]  ex;
   logic [S_FRAC-1:0] fr;
   logic [LZ_W-1:0]   lz;
   logic              seen;
   logic [S_FRAC-1:0] nfr;
   logic [D_EXP-1:0]  nex;

   assign sgn = sval[S_W-1];
   assign ex  = sval[S_W-2 -: S_EXP];
   assign fr  = sval[S_FRAC-1:0];

   always_comb begin
      lz   = '0;
      seen = 1'b0;
      for (int i = S_FRAC - 1; i >= 0; i--) begin
         if (!seen) begin
            if (fr[i]) seen = 1'b1;
            else       lz   = lz + 1'b1;
         end
      end
   end

   assign nfr = S_FRAC'(fr << (lz + LZ_W'(1)));
   assign nex = D_EXP'(BIAS_GAP) - D_EXP'(lz);

   always_comb begin
      unique case (cls)
         CLS_ZERO:           dval = {sgn, {(D_W-1){1'b0}}};
         CLS_DENORM:         dval = {sgn, nex, nfr, {DROP_W{1'b0}}};
         CLS_INF:            dval = {sgn, {D_EXP{1'b1}}, {D_FRAC{1'b0}}};
         CLS_QNAN, CLS_SNAN: dval = {sgn, {D_EXP{1'b1}}, fr, {DROP_W{1'b0}}};
         default:            dval = {sgn, D_EXP'(ex) + D_EXP'(BIAS_GAP), fr,
                                     {DROP_W{1'b0}}};
      endcase
   end
endmodule

// File: rtl/fsc_store_convert.sv
module fsc_store_convert #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [63:0] fpr_value,
   input  logic        tag_single,
   input  logic [1:0]  op_sel,
   output logic        out_valid,
   output logic [63:0] store_data,
   output logic        store_wide
);
   import fsc_pkg::*;

   if (D_W != 64 || S_W != 32 || BIAS_GAP != 896) begin : g_bad_pkg
      $error("fsc_store_convert: package constants inconsistent");
   end

   fp_class_e       cls_dbl, cls_sgl;
   logic [S_W-1:0]  narrow_w;
   logic [D_W-1:0]  widen_w;
   logic [S_W-1:0]  low_w;
   logic [D_W-1:0]  nxt_data;
   logic            nxt_wide;

   assign low_w = fpr_value[S_W-1:0];

   fsc_classify #(.EXP_W(D_EXP), .FRAC_W(D_FRAC)) u_cls_dbl (
      .mag_bits(fpr_value[D_W-2:0]), .cls(cls_dbl));

   fsc_classify #(.EXP_W(S_EXP), .FRAC_W(S_FRAC)) u_cls_sgl (
      .mag_bits(low_w[S_W-2:0]), .cls(cls_sgl));

   fsc_narrow u_narrow (.dval(fpr_value), .cls(cls_dbl), .sval(narrow_w));
   fsc_widen  u_widen  (.sval(low_w),     .cls(cls_sgl), .dval(widen_w));

   always_comb begin
      unique case (st_op_e'(op_sel))
         OP_ST_SGL: begin
            nxt_data = {{(D_W-S_W){1'b0}}, tag_single ? low_w : narrow_w};
            nxt_wide = 1'b0;
         end
         OP_ST_DBL: begin
            nxt_data = tag_single ? widen_w : fpr_value;
            nxt_wide = 1'b1;
         end
         OP_ST_IWD: begin
            nxt_data = {{(D_W-S_W){1'b0}}, low_w};
            nxt_wide = 1'b0;
         end
         default: begin
            nxt_data = '0;
            nxt_wide = 1'b0;
         end
      endcase
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            store_data <= '0;
            store_wide <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               store_data <= nxt_data;
               store_wide <= nxt_wide;
            end
         end
      end
   end else begin : g_comb
      assign out_valid  = in_valid & rst_n;
      assign store_data = rst_n ? nxt_data : '0;
      assign store_wide = rst_n & nxt_wide;
   end
endmodule

// File: rtl/fsc_store_convert_chk.sv
module fsc_store_convert_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [63:0] fpr_value,
   input logic        tag_single,
   input logic [1:0]  op_sel,
   input logic        out_valid,
   input logic [63:0] store_data,
   input logic        store_wide
);
   logic is_snan_d;
   assign is_snan_d = (fpr_value[62:52] == 11'h7FF) && !fpr_value[51] && (|fpr_value[50:0]);

   if (OUT_REG) begin : g_seq
      a_r13_reset_quiet: assert property (@(posedge clk)
         !rst_n |=> !out_valid);

      a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);

      a_r7_double_pass: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_sel == 2'b01 && !tag_single)
         |=> (store_data == $past(fpr_value)) && store_wide);

      a_r1_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_sel == 2'b00 && tag_single)
         |=> (store_data == {32'b0, $past(fpr_value[31:0])}) && !store_wide);

      a_r10_int_word: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_sel == 2'b10)
         |=> (store_data == {32'b0, $past(fpr_value[31:0])}) && !store_wide);

      a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_sel == 2'b11) |=> (store_data == 64'b0) && !store_wide);

      a_r6_snan_not_quieted: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_sel == 2'b00 && !tag_single && is_snan_d)
         |=> (store_data[30:22] == 9'h1FE) && (|store_data[22:0]));
   end else begin : g_cmb
      a_r7_double_pass: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel == 2'b01 && !tag_single) |-> (store_data == fpr_value) && store_wide);

      a_r10_int_word: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel == 2'b10) |-> (store_data == {32'b0, fpr_value[31:0]}) && !store_wide);

      a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel == 2'b11) |-> (store_data == 64'b0));

      a_r6_snan_not_quieted: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel == 2'b00 && !tag_single && is_snan_d)
         |-> (store_data[30:22] == 9'h1FE) && (|store_data[22:0]));
   end
endmodule

bind fsc_store_convert fsc_store_convert_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fpr_value(fpr_value),
   .tag_single(tag_single), .op_sel(op_sel), .out_valid(out_valid),
   .store_data(store_data), .store_wide(store_wide));

// File: tb/tb_fsc_store_convert.sv
`timescale 1ns/1ps
module tb_fsc_store_convert;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] fpr_value = '0;
   logic        tag_single = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic        out_valid;
   logic [63:0] store_data;
   logic        store_wide;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   fsc_store_convert #(.OUT_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fpr_value(fpr_value),
      .tag_single(tag_single), .op_sel(op_sel), .out_valid(out_valid),
      .store_data(store_data), .store_wide(store_wide));

   function automatic real pow2(input int k);
      real r = 1.0;
      if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
      else        for (int i = 0; i < -k; i++) r = r * 0.5;
      return r;
   endfunction

   function automatic logic [31:0] ref_narrow(input logic [63:0] d);
      logic        s = d[63];
      int          e = int'(d[62:52]);
      logic [22:0] t = d[51:29];
      logic [31:0] ee;
      real         q;
      int          n;
      if (e == 0) return {s, 31'b0};
      if (e == 2047) begin
         if (d[51:0] == 52'b0) return {s, 8'hFF, 23'b0};
         if (t == 23'b0) t = 23'd1;
         return {s, 8'hFF, t};
      end
      if (e > 896) begin
         ee = 32'(e - 896);
         return {s, ee[7:0], t};
      end
      q = $bitstoreal({1'b0, d[62:0]}) * pow2(149);
      n = $rtoi(q);
      return {s, 8'b0, n[22:0]};
   endfunction

   function automatic logic [63:0] ref_widen(input logic [31:0] w);
      logic        s  = w[31];
      int          e8 = int'(w[30:23]);
      logic [22:0] f  = w[22:0];
      logic [63:0] b;
      real         m;
      if (e8 == 255) return (f == 23'b0) ? {s, 11'h7FF, 52'b0} : {s, 11'h7FF, f, 29'b0};
      if (e8 == 0 && f == 23'b0) return {s, 63'b0};
      m = (e8 == 0) ? real'(f) * pow2(-149) : (real'(f) + pow2(23)) * pow2(e8 - 150);
      b = $realtobits(m);
      return {s, b[62:0]};
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h (in=%h tag=%0d op=%0d)",
                  req, got, exp, fpr_value, tag_single, op_sel);
      end
   endtask

   task automatic apply(input logic [63:0] v, input bit tg, input logic [1:0] op,
                        input logic [63:0] exp_d, input bit exp_w, input string req);
      @(negedge clk);
      fpr_value = v; tag_single = tg; op_sel = op; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, store_data, exp_d);
      check("R12 valid", {63'b0, out_valid}, 64'd1);
      check({req, " width"}, {63'b0, store_wide}, {63'b0, exp_w});
   endtask

   initial begin
      logic [51:0] dfr [4];
      logic [22:0] sfr [5];
      logic [63:0] v;
      logic [31:0] w;
      dfr[0] = 52'h0; dfr[1] = 52'hFFFFF_FFFFFFFF; dfr[2] = 52'h80000_20000001; dfr[3] = 52'h5A5A5_A5A5A5A5;
      sfr[0] = 23'h0; sfr[1] = 23'h7FFFFF; sfr[2] = 23'h000001; sfr[3] = 23'h2AAAAA; sfr[4] = 23'h400000;

      repeat (3) @(negedge clk);
      // R13: outputs quiet during reset
      check("R13 valid", {63'b0, out_valid}, 64'd0);
      check("R13 data", store_data, 64'd0);
      check("R13 width", {63'b0, store_wide}, 64'd0);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R6: store-single of double-tagged operands across every exponent
      for (int e = 0; e < 2048; e++) begin
         for (int k = 0; k < 4; k++) begin
            v = {e[0] ^ k[0], e[10:0], dfr[k]};
            if (e == 0)          apply(v, 1'b0, 2'b00, {32'b0, ref_narrow(v)}, 1'b0, "R4");
            else if (e == 2047)  apply(v, 1'b0, 2'b00, {32'b0, ref_narrow(v)}, 1'b0, "R5/R6");
            else if (e <= 896)   apply(v, 1'b0, 2'b00, {32'b0, ref_narrow(v)}, 1'b0, "R3");
            else                 apply(v, 1'b0, 2'b00, {32'b0, ref_narrow(v)}, 1'b0, "R2");
         end
      end

      // R3 boundary shifts, explicit values
      apply({1'b0, 11'd896, 52'h0}, 1'b0, 2'b00, {32'b0, 32'h0040_0000}, 1'b0, "R3 shift1");
      apply({1'b1, 11'd874, 52'h0}, 1'b0, 2'b00, {32'b0, 32'h8000_0001}, 1'b0, "R3 shift23");
      apply({1'b0, 11'd873, 52'hFFFFF_FFFFFFF}, 1'b0, 2'b00, 64'h0, 1'b0, "R3 shift24");
      apply({1'b0, 11'd897, 52'h0}, 1'b0, 2'b00, {32'b0, 32'h0080_0000}, 1'b0, "R2 min normal");
      // R6: signaling NaN with only low payload bits keeps NaN, not quieted
      apply({1'b1, 11'h7FF, 52'h00000_00000010}, 1'b0, 2'b00, {32'b0, 32'hFF80_0001}, 1'b0, "R6 sticky");
      apply({1'b0, 11'h7FF, 52'h20000_00000000}, 1'b0, 2'b00, {32'b0, 32'h7F90_0000}, 1'b0, "R6 snan");
      apply({32'b0, 32'h7FA0_0001}, 1'b1, 2'b01, 64'h7FF4_0000_2000_0000, 1'b1, "R6 widen snan");

      // R1 R8 R9: single-tagged operands across every single exponent
      for (int e = 0; e < 256; e++) begin
         for (int k = 0; k < 5; k++) begin
            w = {k[0], e[7:0], sfr[k]};
            v = {$urandom(), w};
            apply(v, 1'b1, 2'b00, {32'b0, w}, 1'b0, "R1");
            if (e == 0 && sfr[k] != 23'b0) apply(v, 1'b1, 2'b01, ref_widen(w), 1'b1, "R9");
            else                           apply(v, 1'b1, 2'b01, ref_widen(w), 1'b1, "R8");
         end
      end
      apply({32'b0, 32'h0000_0001}, 1'b1, 2'b01, 64'h36A0_0000_0000_0000, 1'b1, "R9 smallest");

      // R7 R10 R11: pass-through, integer word and reserved code
      for (int i = 0; i < 200; i++) begin
         v = {$urandom(), $urandom()};
         apply(v, 1'b0, 2'b01, v, 1'b1, "R7");
         apply(v, i[0], 2'b10, {32'b0, v[31:0]}, 1'b0, "R10");
         apply(v, i[1], 2'b11, 64'b0, 1'b0, "R11");
      end
      apply({32'hDEAD_BEEF, 32'h7F80_0001}, 1'b0, 2'b10, 64'h0000_0000_7F80_0001, 1'b0, "R10 nan bits");

      // R12: valid drops the cycle after the request is withdrawn
      @(negedge clk);
      check("R12 drop", {63'b0, out_valid}, 64'd0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule